// File: doc/BRIEF.md
# State-Priority Eviction Victim Selector

This block chooses which way of one set in a set-associative attraction memory should give up its slot. It is asked for a victim in two cases. The first is an inject that needs room. The second is a proactive clean-up that starts when the set is nearly full and the protocol controller has nothing else to do.

The choice is made first on the coherence state of each way, and recency is consulted only for Exclusive ways. Empty ways go first, then Clone copies, then Original copies, then Exclusive ways in least-recently-used order. Ways in the middle of migration are never offered. If an inject finds every way migrating, the block says whether the inject should wait in the local waiting buffer or be sent on to another site.

Recency is kept inside the block as one age matrix per set. Every processor access to a way updates it.

Top module: `evict_victim_sel`

## Requirements
- R1: Each way state is a 3-bit code in `wayStates[3w+2:3w]`: 0 empty (Invalid), 1 Clone, 2 Original, 3 Exclusive, and 4 to 7 Leaving. On an inject, if any way is empty, the lowest-indexed empty way is the victim.
- R2: On an inject with no empty way, the lowest-indexed Clone way is the victim.
- R3: On an inject with no empty or Clone way, the lowest-indexed Original way is the victim.
- R4: On an inject where only Exclusive and Leaving ways exist, the least recently used Exclusive way of the addressed set is the victim.
- R5: A Leaving way (codes 4 to 7) is never reported as a victim.
- R6: An inject that finds every way Leaving reports `noVictim`. If `waitBufFull` is 0, `holdInject` is also set and `forwardInject` is clear.
- R7: An inject that finds every way Leaving while `waitBufFull` is 1 reports `noVictim` and `forwardInject`, and `holdInject` is clear.
- R8: Recency works as follows.
  - A pulse on `touchValid` makes `touchWay` of `touchSet` the most recently used way of that set, from the next cycle on.
  - After reset, a lower way index counts as less recently used.
  - An evaluation in the same cycle as a touch uses the recency from before that touch.
- R9: A proactive eviction is reported when all of the following hold in a cycle:
  - there is no inject;
  - `ctrlIdle` is 1;
  - `fullThresh` is nonzero;
  - the number of non-empty ways (Leaving included) is at least `fullThresh`.
  
  Its victim follows the order Clone, then Original, then least recently used Exclusive, and `proactiveEvict` marks it.
- R10: No victim and no `noVictim` is reported in the following cycles:
  - with no inject, when `ctrlIdle` is 0, when `fullThresh` is 0, or when the occupancy is below the threshold;
  - when a proactive candidate would be only empty or Leaving ways.
  
  An inject takes precedence over a proactive eviction.
- R11: All outputs are registered. They reflect the inputs of the previous clock cycle, are single-cycle pulses, and are all 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| setIdx | input | SET_W | Set being evaluated |
| wayStates | input | NUM_WAYS*3 | Coherence state code of each way of that set |
| touchValid | input | 1 | Processor access strobe for recency update |
| touchSet | input | SET_W | Set of the processor access |
| touchWay | input | WAY_W | Way of the processor access |
| injectReq | input | 1 | An inject needs a slot in `setIdx` |
| ctrlIdle | input | 1 | Controller idle, proactive eviction allowed |
| fullThresh | input | CNT_W | Occupancy threshold for proactive eviction, 0 disables |
| waitBufFull | input | 1 | Local waiting buffer has no room |
| victimValid | output | 1 | A victim way was chosen |
| victimWay | output | WAY_W | The chosen way |
| proactiveEvict | output | 1 | The victim comes from the proactive path |
| noVictim | output | 1 | Inject found only Leaving ways |
| holdInject | output | 1 | Park the inject in the waiting buffer |
| forwardInject | output | 1 | Forward the inject to another site |

## Verification
A corrupted age matrix shows only when an inject or proactive request lands on a set whose candidates are all Exclusive. The reported way then differs from the least recently used one in the next cycle. The stimulus therefore mixes touches with requests that favour Exclusive-heavy sets, so that stale recency surfaces within a few requests.

A wrong class decode or occupancy count shows immediately as a wrong way or a missing or extra pulse one cycle after the request. Every cycle of the run is compared against a model that tracks access order with timestamps.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_EMPTY = 3'd0,
    ST_CLONE = 3'd1,
    ST_ORIG  = 3'd2,
    ST_EXCL  = 3'd3,
    ST_LEAVE = 3'd4
  } wayState_e;

  typedef struct packed {
    logic pickInject;
    logic pickProactive;
    logic parkInject;
    logic sendOnward;
    logic touch;
  } evsStrobe_t;
endpackage

// File: rtl/evs_age_matrix.sv
module evs_age_matrix #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               touchEn,
  input  logic [SET_W-1:0]                   touchSet,
  input  logic [WAY_W-1:0]                   touchWay,
  input  logic [SET_W-1:0]                   rdSet,
  output logic [NUM_WAYS-1:0][NUM_WAYS-1:0]  olderRow
);
  logic [NUM_WAYS-1:0][NUM_WAYS-1:0] ageAll [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic [NUM_WAYS-1:0][NUM_WAYS-1:0] ageQ;
    logic hitSet;
    assign hitSet = touchEn && (touchSet == SET_W'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < NUM_WAYS; i++)
          for (int j = 0; j < NUM_WAYS; j++)
            ageQ[i][j] <= (i < j);
      end else if (hitSet) begin
        for (int i = 0; i < NUM_WAYS; i++)
          for (int j = 0; j < NUM_WAYS; j++) begin
            if (touchWay == WAY_W'(i))      ageQ[i][j] <= 1'b0;
            else if (touchWay == WAY_W'(j)) ageQ[i][j] <= 1'b1;
          end
      end
    end

    assign ageAll[s] = ageQ;
  end

  assign olderRow = ageAll[rdSet];
endmodule

// File: rtl/evs_datapath.sv
module evs_datapath
  import evs_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int CNT_W = $clog2(NUM_WAYS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  evsStrobe_t                  strobe,
  input  logic [SET_W-1:0]            setIdx,
  input  logic [NUM_WAYS*STATE_W-1:0] wayStates,
  input  logic [SET_W-1:0]            touchSet,
  input  logic [WAY_W-1:0]            touchWay,
  input  logic [CNT_W-1:0]            fullThresh,
  output logic                        occHit,
  output logic                        anyInjCand,
  output logic                        anyProCand,
  output logic                        victimValid,
  output logic [WAY_W-1:0]            victimWay,
  output logic                        proactiveEvict,
  output logic                        noVictim,
  output logic                        holdInject,
  output logic                        forwardInject
);
  logic [NUM_WAYS-1:0][NUM_WAYS-1:0] olderRow;
  logic [NUM_WAYS-1:0] isEmpty, isClone, isOrig, isExcl;
  logic [CNT_W-1:0]    occCnt;
  logic [WAY_W-1:0]    emptyIdx, cloneIdx, origIdx, lruIdx, injPick, proPick;
  logic anyEmpty, anyClone, anyOrig, anyExcl;

  evs_age_matrix #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_age (
    .clk      (clk),
    .rstN     (rstN),
    .touchEn  (strobe.touch),
    .touchSet (touchSet),
    .touchWay (touchWay),
    .rdSet    (setIdx),
    .olderRow (olderRow)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_decode
    logic [STATE_W-1:0] code;
    assign code       = wayStates[w*STATE_W +: STATE_W];
    assign isEmpty[w] = (code == ST_EMPTY);
    assign isClone[w] = (code == ST_CLONE);
    assign isOrig[w]  = (code == ST_ORIG);
    assign isExcl[w]  = (code == ST_EXCL);
  end

  assign anyEmpty = |isEmpty;
  assign anyClone = |isClone;
  assign anyOrig  = |isOrig;
  assign anyExcl  = |isExcl;

  always_comb begin
    occCnt = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (!isEmpty[w]) occCnt = occCnt + CNT_W'(1);
  end

  always_comb begin
    emptyIdx = '0;
    cloneIdx = '0;
    origIdx  = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (isEmpty[w]) emptyIdx = WAY_W'(w);
      if (isClone[w]) cloneIdx = WAY_W'(w);
      if (isOrig[w])  origIdx  = WAY_W'(w);
    end
  end

  always_comb begin
    logic oldest;
    lruIdx = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      oldest = isExcl[w];
      for (int j = 0; j < NUM_WAYS; j++)
        if (j != w && isExcl[j] && !olderRow[w][j]) oldest = 1'b0;
      if (oldest) lruIdx = WAY_W'(w);
    end
  end

  always_comb begin
    if (anyClone)     proPick = cloneIdx;
    else if (anyOrig) proPick = origIdx;
    else              proPick = lruIdx;
    injPick = anyEmpty ? emptyIdx : proPick;
  end

  assign anyProCand = anyClone | anyOrig | anyExcl;
  assign anyInjCand = anyEmpty | anyProCand;
  assign occHit     = (fullThresh != '0) && (occCnt >= fullThresh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victimValid    <= 1'b0;
      victimWay      <= '0;
      proactiveEvict <= 1'b0;
      noVictim       <= 1'b0;
      holdInject     <= 1'b0;
      forwardInject  <= 1'b0;
    end else begin
      victimValid    <= strobe.pickInject | strobe.pickProactive;
      proactiveEvict <= strobe.pickProactive;
      noVictim       <= strobe.parkInject | strobe.sendOnward;
      holdInject     <= strobe.parkInject;
      forwardInject  <= strobe.sendOnward;
      if (strobe.pickInject)         victimWay <= injPick;
      else if (strobe.pickProactive) victimWay <= proPick;
    end
  end
endmodule

// File: rtl/evs_control.sv
module evs_control
  import evs_pkg::*;
(
  input  logic       injectReq,
  input  logic       ctrlIdle,
  input  logic       touchValid,
  input  logic       waitBufFull,
  input  logic       occHit,
  input  logic       anyInjCand,
  input  logic       anyProCand,
  output evsStrobe_t strobe
);
  always_comb begin
    strobe               = '0;
    strobe.touch         = touchValid;
    strobe.pickInject    = injectReq && anyInjCand;
    strobe.parkInject    = injectReq && !anyInjCand && !waitBufFull;
    strobe.sendOnward    = injectReq && !anyInjCand && waitBufFull;
    strobe.pickProactive = !injectReq && ctrlIdle && occHit && anyProCand;
  end
endmodule

// File: rtl/evict_victim_sel.sv
module evict_victim_sel
  import evs_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int CNT_W = $clog2(NUM_WAYS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SET_W-1:0]            setIdx,
  input  logic [NUM_WAYS*3-1:0]       wayStates,
  input  logic                        touchValid,
  input  logic [SET_W-1:0]            touchSet,
  input  logic [WAY_W-1:0]            touchWay,
  input  logic                        injectReq,
  input  logic                        ctrlIdle,
  input  logic [CNT_W-1:0]            fullThresh,
  input  logic                        waitBufFull,
  output logic                        victimValid,
  output logic [WAY_W-1:0]            victimWay,
  output logic                        proactiveEvict,
  output logic                        noVictim,
  output logic                        holdInject,
  output logic                        forwardInject
);
  evsStrobe_t strobe;
  logic occHit, anyInjCand, anyProCand;

  evs_control u_ctrl (
    .injectReq   (injectReq),
    .ctrlIdle    (ctrlIdle),
    .touchValid  (touchValid),
    .waitBufFull (waitBufFull),
    .occHit      (occHit),
    .anyInjCand  (anyInjCand),
    .anyProCand  (anyProCand),
    .strobe      (strobe)
  );

  evs_datapath #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .setIdx         (setIdx),
    .wayStates      (wayStates),
    .touchSet       (touchSet),
    .touchWay       (touchWay),
    .fullThresh     (fullThresh),
    .occHit         (occHit),
    .anyInjCand     (anyInjCand),
    .anyProCand     (anyProCand),
    .victimValid    (victimValid),
    .victimWay      (victimWay),
    .proactiveEvict (proactiveEvict),
    .noVictim       (noVictim),
    .holdInject     (holdInject),
    .forwardInject  (forwardInject)
  );
endmodule

// File: rtl/evs_checker.sv
module evs_checker #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int CNT_W = $clog2(NUM_WAYS + 1)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [SET_W-1:0]      setIdx,
  input logic [NUM_WAYS*3-1:0] wayStates,
  input logic                  touchValid,
  input logic [SET_W-1:0]      touchSet,
  input logic [WAY_W-1:0]      touchWay,
  input logic                  injectReq,
  input logic                  ctrlIdle,
  input logic [CNT_W-1:0]      fullThresh,
  input logic                  waitBufFull,
  input logic                  victimValid,
  input logic [WAY_W-1:0]      victimWay,
  input logic                  proactiveEvict,
  input logic                  noVictim,
  input logic                  holdInject,
  input logic                  forwardInject
);
  logic [NUM_WAYS*3-1:0] pastStates;
  logic                  pastAnyEmpty;
  logic [2:0]            pickedCode;

  always_ff @(posedge clk) pastStates <= wayStates;

  always_comb begin
    pastAnyEmpty = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (pastStates[w*3 +: 3] == 3'd0) pastAnyEmpty = 1'b1;
  end

  assign pickedCode = pastStates[int'(victimWay)*3 +: 3];

  assert_empty_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    (victimValid && !proactiveEvict && pastAnyEmpty) |-> (pickedCode == 3'd0));

  assert_never_leaving_R5: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> (pickedCode < 3'd4));

  assert_park_R6: assert property (@(posedge clk) disable iff (!rstN)
    holdInject |-> (noVictim && !forwardInject && !$past(waitBufFull) && $past(injectReq)));

  assert_forward_R7: assert property (@(posedge clk) disable iff (!rstN)
    forwardInject |-> (noVictim && !holdInject && $past(waitBufFull) && $past(injectReq)));

  assert_proactive_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    proactiveEvict |-> (victimValid && pickedCode != 3'd0 && $past(ctrlIdle) && !$past(injectReq)));

  assert_inject_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    (victimValid && !proactiveEvict) |-> $past(injectReq));

  assert_outcome_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(victimValid && noVictim));

  assert_novictim_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    noVictim |-> ($past(injectReq) && (holdInject || forwardInject)));
endmodule

bind evict_victim_sel evs_checker #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_chk (.*);

// File: tb/evict_victim_sel_tb.sv
`timescale 1ns/100ps
module evict_victim_sel_tb;
  localparam int NW = 4;
  localparam int NS = 8;
  localparam int WAY_W = $clog2(NW);
  localparam int SET_W = $clog2(NS);
  localparam int CNT_W = $clog2(NW + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [SET_W-1:0] setIdx = '0;
  logic [NW*3-1:0]  wayStates = '0;
  logic             touchValid = 1'b0;
  logic [SET_W-1:0] touchSet = '0;
  logic [WAY_W-1:0] touchWay = '0;
  logic             injectReq = 1'b0;
  logic             ctrlIdle = 1'b0;
  logic [CNT_W-1:0] fullThresh = '0;
  logic             waitBufFull = 1'b0;
  logic             victimValid, proactiveEvict, noVictim, holdInject, forwardInject;
  logic [WAY_W-1:0] victimWay;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int stamp [NS][NW];
  int stampCtr;

  always #2.5 clk = ~clk;

  evict_victim_sel #(.NUM_WAYS(NW), .NUM_SETS(NS)) u_dut (.*);

  function automatic logic [2:0] codeOf(input int w);
    return wayStates[w*3 +: 3];
  endfunction

  // Expected outputs: {valid, way, proactive, none, hold, forward}
  task automatic expect_now(output logic [WAY_W+4:0] exp, output string tag);
    int pick = -1;
    int occ = 0;
    logic pro = 1'b0;
    tag = "R10";
    for (int w = 0; w < NW; w++) if (codeOf(w) != 3'd0) occ++;
    if (injectReq) begin
      for (int w = NW - 1; w >= 0; w--) if (codeOf(w) == 3'd0) begin pick = w; tag = "R1"; end
    end
    if (injectReq || (ctrlIdle && fullThresh != 0 && occ >= int'(fullThresh))) begin
      if (pick < 0) for (int w = NW - 1; w >= 0; w--) if (codeOf(w) == 3'd1) begin pick = w; tag = "R2"; end
      if (pick < 0) for (int w = NW - 1; w >= 0; w--) if (codeOf(w) == 3'd2) begin pick = w; tag = "R3"; end
      if (pick < 0) begin
        int best = 32'h7fffffff;
        for (int w = 0; w < NW; w++)
          if (codeOf(w) == 3'd3 && stamp[setIdx][w] < best) begin
            best = stamp[setIdx][w]; pick = w; tag = "R4/R8";
          end
      end
      if (!injectReq) begin pro = 1'b1; if (pick >= 0) tag = "R9"; end
    end
    if (pick >= 0)
      exp = {1'b1, WAY_W'(pick), pro, 3'b000};
    else if (injectReq)
      exp = {1'b0, WAY_W'(0), 1'b0, 1'b1, !waitBufFull, waitBufFull};
    else
      exp = '0;
    if (injectReq && pick < 0) tag = waitBufFull ? "R7" : "R6";
    if (injectReq && pick >= 0 && tag != "R1") tag = {tag, "/R5"};
  endtask

  task automatic cycle();
    logic [WAY_W+4:0] exp, got;
    string tag;
    expect_now(exp, tag);
    if (touchValid) begin
      stamp[touchSet][touchWay] = stampCtr;
      stampCtr++;
    end
    @(posedge clk);
    #1;
    got = {victimValid, victimWay, proactiveEvict, noVictim, holdInject, forwardInject};
    if (!exp[WAY_W+4]) got[WAY_W+3:4] = '0;
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic quiet();
    touchValid = 0; injectReq = 0; ctrlIdle = 0; fullThresh = '0; waitBufFull = 0;
  endtask

  task automatic touch(input int s, input int w);
    quiet();
    touchValid = 1; touchSet = SET_W'(s); touchWay = WAY_W'(w);
    cycle();
    touchValid = 0;
  endtask

  task automatic inject(input int s, input logic [NW*3-1:0] st, input logic bf);
    quiet();
    setIdx = SET_W'(s); wayStates = st; injectReq = 1; waitBufFull = bf;
    cycle();
    injectReq = 0;
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) stamp[s][w] = w;
    stampCtr = NW;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R11: outputs idle after reset
    cycle();
    // R1: empty ways present, lowest index wins
    inject(0, {3'd3, 3'd0, 3'd1, 3'd0}, 0);
    // R2: clone before original and exclusive
    inject(1, {3'd1, 3'd2, 3'd3, 3'd4}, 0);
    // R3: original before exclusive
    inject(1, {3'd2, 3'd3, 3'd4, 3'd3}, 0);
    // R8: reset recency, lowest index least recent
    inject(2, {3'd3, 3'd3, 3'd3, 3'd3}, 0);
    touch(2, 0); touch(2, 1);
    // R4: LRU exclusive after touches
    inject(2, {3'd3, 3'd3, 3'd3, 3'd3}, 0);
    inject(2, {3'd3, 3'd3, 3'd5, 3'd3}, 0);
    // R5: only one non-leaving way
    inject(3, {3'd7, 3'd3, 3'd6, 3'd4}, 0);
    // R6 and R7: all leaving
    inject(4, {3'd4, 3'd5, 3'd6, 3'd7}, 0);
    inject(4, {3'd4, 3'd4, 3'd4, 3'd4}, 1);
    // R9: proactive at threshold
    quiet(); setIdx = 5; wayStates = {3'd0, 3'd3, 3'd2, 3'd0}; ctrlIdle = 1; fullThresh = 2; cycle();
    // R10: not idle, threshold zero, below threshold, only leaving candidates
    ctrlIdle = 0; cycle();
    ctrlIdle = 1; fullThresh = 0; cycle();
    fullThresh = 3; cycle();
    wayStates = {3'd4, 3'd4, 3'd0, 3'd4}; fullThresh = 2; cycle();
    // R10: inject beats proactive
    wayStates = {3'd1, 3'd0, 3'd2, 3'd3}; injectReq = 1; cycle();
    quiet();
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      setIdx = SET_W'($urandom_range(0, NS - 1));
      for (int w = 0; w < NW; w++) begin
        int r = $urandom_range(0, 9);
        wayStates[w*3 +: 3] = (r < 2) ? 3'd0 : (r < 4) ? 3'd1 : (r < 6) ? 3'd2 :
                              (r < 9) ? 3'd3 : 3'($urandom_range(4, 7));
      end
      touchValid  = ($urandom_range(0, 1) == 1);
      touchSet    = ($urandom_range(0, 1) == 1) ? setIdx : SET_W'($urandom_range(0, NS - 1));
      touchWay    = WAY_W'($urandom_range(0, NW - 1));
      injectReq   = ($urandom_range(0, 9) < 4);
      ctrlIdle    = ($urandom_range(0, 1) == 1);
      fullThresh  = CNT_W'($urandom_range(0, NW));
      waitBufFull = ($urandom_range(0, 1) == 1);
      cycle();
    end
    quiet();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule